// File: doc/BRIEF.md
# Shared Memory Arbiter with Atomic Sequence Lock-On

This block sits in front of one shared memory module and serves a set of processor request ports. Each port offers a request through a valid/ready handshake. The request carries an address, write data, a direction flag and an indivisibility flag. When no atomic sequence is open, the arbiter picks one of the requesting ports with a round-robin pointer. That pointer always restarts its search just past the port it granted last. The arbiter then forwards the chosen request to the memory.

A port opens an atomic sequence by getting a request accepted with its indivisibility flag set. From then on the arbiter serves only that port. Requests waiting on other ports stay pending with ready held low, and none is dropped. The owner's next request that has the flag cleared closes the sequence. Once that request is served, arbitration is free again. A request with the flag cleared that arrives while no sequence is open is a plain single access.

The memory takes a request in the cycle where both its request strobe and its ready input are high. It returns read data one cycle later. The arbiter passes that data back with a one-cycle response strobe aimed at the port that issued the read. The lock state and the index of the owning port are visible as outputs.

Top module: `seq_lock_arbiter`

## Requirements
- R1: After reset, no sequence is open, no response strobe is high, and the first free grant goes to the lowest requesting port at or above index 0.
- R2: With no sequence open, the arbiter grants the first requesting port found when searching upward (wrapping at N) from the port after the one granted last.
- R3: At most one port sees ready high in a cycle, and only a port that has valid high while the memory ready input is high.
- R4: The memory address, write data and direction outputs carry the fields of the port being granted, so that a write followed by a read to the same address returns the written value.
- R5: One cycle after a read is accepted, the response strobe is high for that port alone and the response data equals the memory read data of that cycle. There is no response strobe after a write.
- R6: Accepting a request with the indivisibility flag at 1 opens a sequence. In the next cycle the lock output is 1 and the owner index equals the granted port.
- R7: While a sequence is open, no other port gets ready, even when the owner is idle. Their requests stay pending and are served after the sequence closes.
- R8: Accepting the owner's request with the flag at 0 closes the sequence. The lock output falls the next cycle and free round-robin arbitration resumes.
- R9: A request with the flag at 0 accepted with no sequence open is a single access and leaves the lock output at 0.
- R10: While the memory ready input is low, no request is accepted, and both the lock state and the round-robin position are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | N | Per-port request valid |
| reqWrite | input | N | Per-port direction, 1 = write |
| reqIndiv | input | N | Per-port indivisibility flag |
| reqAddr | input | N*ADDR_W | Per-port address, port i at bits i*ADDR_W upward |
| reqWdata | input | N*DATA_W | Per-port write data, port i at bits i*DATA_W upward |
| reqReady | output | N | Per-port acceptance |
| rspValid | output | N | Per-port read response strobe |
| rspData | output | DATA_W | Read data shared by all ports |
| memReq | output | 1 | Request strobe to memory |
| memWrite | output | 1 | Direction to memory |
| memAddr | output | ADDR_W | Address to memory |
| memWdata | output | DATA_W | Write data to memory |
| memReady | input | 1 | Memory accepts the request this cycle |
| memRdata | input | DATA_W | Read data, valid the cycle after an accepted read |
| lockActive | output | 1 | An atomic sequence is open |
| lockPort | output | max(1,clog2(N)) | Index of the owning port |

## Verification
The bench builds the block with its defaults: four ports, 8-bit addresses and 16-bit data. Four ports are enough for the search to skip idle ports and wrap past the top index. They also leave several non-owners pending during a sequence, while a sequence owner sits at the lowest, a middle and the top index. The 8-bit address space lets the bench's memory model keep the read and write regions apart, so every read result is predictable. Stalls from the memory ready input are placed both inside and outside open sequences.

// File: rtl/seq_arb_pkg.sv
package seq_arb_pkg;
  // Upper bound on the selector width carried between control and datapath
  localparam int SEL_W = 8;

  typedef struct packed {
    logic             issue;  // a request is presented to memory
    logic             fire;   // that request is accepted this cycle
    logic [SEL_W-1:0] sel;    // index of the selected port
  } arb_strobe_t;
endpackage

// File: rtl/seq_arb_ctrl.sv
module seq_arb_ctrl
  import seq_arb_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  reqValid,
  input  logic [N-1:0]  reqIndiv,
  input  logic          memReady,
  output arb_strobe_t   strobe,
  output logic          lockActive,
  output logic [IW-1:0] lockPort
);
  logic          locked;
  logic [IW-1:0] owner;
  logic [IW-1:0] lastPtr;
  logic          found;
  logic [IW-1:0] pick;
  logic          fire;

  // Selection: owner only while locked, else round-robin after lastPtr
  always_comb begin
    found = 1'b0;
    pick  = '0;
    if (locked) begin
      if (reqValid[owner]) begin
        found = 1'b1;
        pick  = owner;
      end
    end else begin
      for (int k = 1; k <= N; k++) begin
        if (!found && reqValid[(int'(lastPtr) + k) % N]) begin
          found = 1'b1;
          pick  = IW'((int'(lastPtr) + k) % N);
        end
      end
    end
  end

  assign fire         = found && memReady;
  assign strobe.issue = found;
  assign strobe.fire  = fire;
  assign strobe.sel   = SEL_W'(pick);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked  <= 1'b0;
      owner   <= '0;
      lastPtr <= IW'(N - 1);
    end else if (fire) begin
      lastPtr <= pick;
      owner   <= pick;
      locked  <= reqIndiv[pick];
    end
  end

  assign lockActive = locked;
  assign lockPort   = owner;

  // R6
  lock_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && reqIndiv[pick]) |=> (lockActive && lockPort == $past(pick)));

  // R8
  lock_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !reqIndiv[pick]) |=> !lockActive);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memReady) |=> ($stable(lockActive) && $stable(lockPort)));
endmodule

// File: rtl/seq_arb_dp.sv
module seq_arb_dp
  import seq_arb_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  arb_strobe_t         strobe,
  input  logic [N-1:0]        reqValid,
  input  logic [N-1:0]        reqWrite,
  input  logic [N*ADDR_W-1:0] reqAddr,
  input  logic [N*DATA_W-1:0] reqWdata,
  input  logic                memReady,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [N-1:0]        reqReady,
  output logic [N-1:0]        rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic                memReq,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata
);
  // Route the selected port's fields to memory
  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    memWrite = 1'b0;
    reqReady = '0;
    for (int i = 0; i < N; i++) begin
      if (strobe.sel == SEL_W'(i)) begin
        memAddr     = reqAddr[i*ADDR_W +: ADDR_W];
        memWdata    = reqWdata[i*DATA_W +: DATA_W];
        memWrite    = reqWrite[i];
        reqReady[i] = strobe.fire;
      end
    end
  end

  assign memReq = strobe.issue;

  // Response strobe: one cycle after an accepted read, to that port
  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= '0;
    else       rspValid <= (strobe.fire && !memWrite) ? reqReady : '0;
  end

  assign rspData = memRdata;

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady));

  // R3
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|reqReady) |-> (memReady && ((reqValid & reqReady) == reqReady)));

  // R5
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|rspValid) |-> ($past(|reqReady && !memWrite) && rspValid == $past(reqReady)));
endmodule

// File: rtl/seq_lock_arbiter.sv
module seq_lock_arbiter
  import seq_arb_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [N-1:0]        reqValid,
  input  logic [N-1:0]        reqWrite,
  input  logic [N-1:0]        reqIndiv,
  input  logic [N*ADDR_W-1:0] reqAddr,
  input  logic [N*DATA_W-1:0] reqWdata,
  output logic [N-1:0]        reqReady,
  output logic [N-1:0]        rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic                memReq,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic                memReady,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                lockActive,
  output logic [IW-1:0]       lockPort
);
  arb_strobe_t strobe;

  seq_arb_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqIndiv   (reqIndiv),
    .memReady   (memReady),
    .strobe     (strobe),
    .lockActive (lockActive),
    .lockPort   (lockPort)
  );

  seq_arb_dp #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memReady (memReady),
    .memRdata (memRdata),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspData  (rspData),
    .memReq   (memReq),
    .memWrite (memWrite),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  // R7
  owner_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |-> ((reqReady & ~(N'(1) << lockPort)) == '0));
endmodule

// File: tb/seq_lock_arbiter_tb.sv
`timescale 1ns/1ps
module seq_lock_arbiter_tb;
  localparam int N = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  reqValid = '0, reqWrite = '0, reqIndiv = '0;
  logic [N*AW-1:0] reqAddr = '0;
  logic [N*DW-1:0] reqWdata = '0;
  logic [N-1:0]  reqReady, rspValid;
  logic [DW-1:0] rspData;
  logic          memReq, memWrite;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memReady = 1'b1;
  logic [DW-1:0] memRdata = '0;
  logic          lockActive;
  logic [1:0]    lockPort;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seq_lock_arbiter #(.N(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIndiv(reqIndiv), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memReady(memReady), .memRdata(memRdata),
    .lockActive(lockActive), .lockPort(lockPort)
  );

  // Memory model: one-cycle read latency, initial pattern addr*7+3
  logic [DW-1:0] mem [256];
  initial for (int a = 0; a < 256; a++) mem[a] = DW'(a * 7 + 3);
  always @(posedge clk) begin
    if (memReq && memReady) begin
      if (memWrite) mem[memAddr] <= memWdata;
      else          memRdata <= mem[memAddr];
    end
  end

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 7 + 3);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0] valid;
    logic [3:0] indiv;
    logic [3:0] write;
    logic       rdy;
    logic [3:0] expReady;
    logic       expLock;
    logic [1:0] expPort;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 4'b0000, 4'b0000, 1'b1, 4'b0000, 1'b0, 2'd0}, // idle
    '{4'b1111, 4'b0000, 4'b0000, 1'b1, 4'b0001, 1'b0, 2'd0}, // R1 first grant port0
    '{4'b1111, 4'b0000, 4'b0000, 1'b1, 4'b0010, 1'b0, 2'd0}, // R2 rotate
    '{4'b1010, 4'b0000, 4'b0000, 1'b1, 4'b1000, 1'b0, 2'd0}, // R2 skip idle
    '{4'b0100, 4'b0100, 4'b0000, 1'b1, 4'b0100, 1'b1, 2'd2}, // R6 open on 2
    '{4'b1011, 4'b0000, 4'b0000, 1'b1, 4'b0000, 1'b1, 2'd2}, // R7 owner idle
    '{4'b1111, 4'b0100, 4'b0000, 1'b1, 4'b0100, 1'b1, 2'd2}, // R7 continue
    '{4'b1111, 4'b0000, 4'b0000, 1'b1, 4'b0100, 1'b0, 2'd0}, // R8 close
    '{4'b1111, 4'b0000, 4'b0000, 1'b1, 4'b1000, 1'b0, 2'd0}, // R8 free again
    '{4'b1111, 4'b0000, 4'b0000, 1'b0, 4'b0000, 1'b0, 2'd0}, // R10 stall
    '{4'b1111, 4'b0000, 4'b0000, 1'b1, 4'b0001, 1'b0, 2'd0}, // R10 pointer kept, wrap
    '{4'b0001, 4'b0001, 4'b0001, 1'b1, 4'b0001, 1'b1, 2'd0}, // R6 open on 0 by write
    '{4'b1110, 4'b0000, 4'b0000, 1'b1, 4'b0000, 1'b1, 2'd0}, // R7 others blocked
    '{4'b1111, 4'b0001, 4'b0000, 1'b0, 4'b0000, 1'b1, 2'd0}, // R10 stall while locked
    '{4'b1111, 4'b0000, 4'b0000, 1'b1, 4'b0001, 1'b0, 2'd0}, // R8 close on 0
    '{4'b0010, 4'b0000, 4'b0000, 1'b1, 4'b0010, 1'b0, 2'd0}  // R9 single access
  };

  task automatic setPort(input int p, input bit v, input bit w, input bit ind,
                         input int a, input int d);
    reqValid[p] = v;
    reqWrite[p] = w;
    reqIndiv[p] = ind;
    reqAddr[p*AW +: AW] = AW'(a);
    reqWdata[p*DW +: DW] = DW'(d);
  endtask

  task automatic idleAll();
    for (int p = 0; p < N; p++) setPort(p, 1'b0, 1'b0, 1'b0, 0, 0);
  endtask

  initial begin
    int expRspPort;
    int expRspAddr;
    bit prevLock;
    int prevPort;

    // Reset state, R1
    repeat (3) @(negedge clk);
    chk(lockActive == 1'b0, "R1 lockActive in reset", int'(lockActive), 0);
    chk(rspValid == '0, "R1 rspValid in reset", int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(lockActive == 1'b0, "R1 lockActive after reset", int'(lockActive), 0);
    chk(rspValid == '0 && reqReady == '0 && memReq == 1'b0,
        "R1 idle outputs after reset", int'({memReq, rspValid, reqReady}), 0);

    // Vector table
    expRspPort = -1;
    expRspAddr = 0;
    prevLock = 1'b0;
    prevPort = 0;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      memReady = v.rdy;
      for (int p = 0; p < N; p++) begin
        int a;
        a = v.write[p] ? (128 + i) : (p * 16 + i);
        setPort(p, v.valid[p], v.write[p], v.indiv[p], a, 16'hA000 + i);
      end
      #1;
      chk(reqReady == v.expReady, $sformatf("R2/R3/R7/R10 reqReady vec %0d", i),
          int'(reqReady), int'(v.expReady));
      @(negedge clk);
      // R6/R8/R9 lock state after the edge
      chk(lockActive == v.expLock, $sformatf("R6/R8/R9 lockActive vec %0d", i),
          int'(lockActive), int'(v.expLock));
      if (v.expLock)
        chk(lockPort == v.expPort, $sformatf("R6 lockPort vec %0d", i),
            int'(lockPort), int'(v.expPort));
      // R5 response for this vector
      expRspPort = -1;
      for (int p = 0; p < N; p++)
        if (v.expReady[p] && !v.write[p]) begin
          expRspPort = p;
          expRspAddr = p * 16 + i;
        end
      if (expRspPort >= 0) begin
        chk(rspValid == 4'(1 << expRspPort), $sformatf("R5 rspValid vec %0d", i),
            int'(rspValid), 1 << expRspPort);
        chk(rspData == pat(expRspAddr), $sformatf("R5 rspData vec %0d", i),
            int'(rspData), int'(pat(expRspAddr)));
      end else begin
        chk(rspValid == '0, $sformatf("R5 no response vec %0d", i), int'(rspValid), 0);
      end
      prevLock = v.expLock;
      prevPort = int'(v.expPort);
    end

    // R4: write then read back through port 1 (pointer now at 1)
    idleAll();
    memReady = 1'b1;
    @(negedge clk);
    setPort(1, 1'b1, 1'b1, 1'b0, 8'h40, 16'h1234);
    #1;
    chk(reqReady == 4'b0010, "R4 write grant", int'(reqReady), 2);
    chk(memWrite == 1'b1 && memAddr == 8'h40 && memWdata == 16'h1234,
        "R4 memory fields on write", int'({memWrite, memAddr, memWdata}),
        int'({1'b1, 8'h40, 16'h1234}));
    @(negedge clk);
    chk(rspValid == '0, "R5 no response after write", int'(rspValid), 0);
    setPort(1, 1'b1, 1'b0, 1'b0, 8'h40, 0);
    #1;
    chk(reqReady == 4'b0010 && memAddr == 8'h40 && memWrite == 1'b0,
        "R4 read fields", int'({reqReady, memWrite, memAddr}), int'({4'b0010, 1'b0, 8'h40}));
    @(negedge clk);
    chk(rspValid == 4'b0010, "R5 readback strobe", int'(rspValid), 2);
    chk(rspData == 16'h1234, "R4 readback data", int'(rspData), 16'h1234);

    // R7: pending request on port 0 held across a sequence owned by port 3
    idleAll();
    setPort(3, 1'b1, 1'b0, 1'b1, 8'h33, 0);
    setPort(0, 1'b1, 1'b0, 1'b0, 8'h05, 0);
    #1;
    chk(reqReady == 4'b1000, "R2 search after port1 picks 3", int'(reqReady), 8);
    @(negedge clk);
    chk(lockActive && lockPort == 2'd3, "R6 lock on port3",
        int'({lockActive, lockPort}), int'({1'b1, 2'd3}));
    reqValid[3] = 1'b0;
    #1;
    chk(reqReady == '0, "R7 port0 held while owner idle", int'(reqReady), 0);
    @(negedge clk);
    setPort(3, 1'b1, 1'b0, 1'b0, 8'h34, 0);
    #1;
    chk(reqReady == 4'b1000, "R8 closing request from owner", int'(reqReady), 8);
    @(negedge clk);
    chk(lockActive == 1'b0, "R8 lock released", int'(lockActive), 0);
    chk(rspData == pat(8'h34), "R5 closing read data", int'(rspData), int'(pat(8'h34)));
    reqValid[3] = 1'b0;
    #1;
    chk(reqReady == 4'b0001, "R7 held port0 served", int'(reqReady), 1);
    @(negedge clk);
    chk(rspValid == 4'b0001 && rspData == pat(5), "R7 held read returned",
        int'({rspValid, rspData}), int'({4'b0001, pat(5)}));

    // R1: reset in the middle of a sequence
    idleAll();
    setPort(2, 1'b1, 1'b0, 1'b1, 8'h21, 0);
    @(negedge clk);
    chk(lockActive == 1'b1, "R6 lock before reset", int'(lockActive), 1);
    idleAll();
    rstN = 1'b0;
    @(negedge clk);
    chk(lockActive == 1'b0 && rspValid == '0, "R1 reset clears lock",
        int'({lockActive, rspValid}), 0);
    rstN = 1'b1;
    setPort(1, 1'b1, 1'b0, 1'b0, 8'h11, 0);
    setPort(2, 1'b1, 1'b0, 1'b0, 8'h22, 0);
    #1;
    chk(reqReady == 4'b0010, "R1 first grant after reset", int'(reqReady), 2);
    @(negedge clk);
    idleAll();
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule